// File: doc/BRIEF.md
# Synthesizer Control Word Register

This block holds the control word that sets up a PLL frequency synthesizer. The word has three fields: a 9-bit feedback divider, a 2-bit post-divider code and a 3-bit test-mode select. Two paths can write the word, and both write the same set of configuration registers.

The serial path is a three-wire port with a clock, a data line and a load strobe. Each rising edge of the serial clock moves one bit into a 14-bit shift register. A falling edge of the load strobe copies the shift register into the configuration registers. The parallel path captures the divider and post-divider inputs directly on a rising edge of its own strobe. The parallel path wins over the serial path. While the parallel strobe is low, the serial path is locked out.

All strobes and the serial clock are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are detected in the system clock domain. The parallel data inputs are taken to be quasi-static around their strobe. The block also decodes the post-divider code into a one-hot divide ratio and flags a feedback divider of zero.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the feedback divider reads 0x1FF, the post-divider code reads 2'b11, the test select reads 3'b000, the ratio output reads 4'b1000 and the zero flag is low.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` into the shift register, most significant bit first. A 14-bit word is ordered test[2:0], post[1:0], fb[8:0], so the last bit sent lands in fb[0]. A falling edge of `ser_ld` with `par_ld` high copies that word to the outputs.
- R3: A rising edge of `ser_ld` does not change the outputs. Without a qualifying strobe edge, the outputs hold.
- R4: A rising edge of `par_ld` captures `par_fb` and `par_post` into the outputs and leaves the test select unchanged.
- R5: A falling edge of `ser_ld` while `par_ld` is low is ignored, and all outputs keep their values.
- R6: When a parallel rising edge and a serial falling edge are detected in the same system cycle, the parallel values are taken.
- R7: The ratio output is one-hot. Post code 00 gives bit 0 (divide by 1), 01 gives bit 1 (divide by 2), 10 gives bit 2 (divide by 4) and 11 gives bit 3 (divide by 8).
- R8: `fb_zero` is high exactly when the latched feedback divider is zero. The zero value is still driven on `cfg_fb`.
- R9: When more than 14 bits are shifted before a load, only the last 14 bits are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe, acts on its falling edge |
| par_ld | input | 1 | Parallel load strobe, acts on its rising edge |
| par_fb | input | 9 | Parallel feedback divider value |
| par_post | input | 2 | Parallel post-divider code |
| cfg_fb | output | 9 | Latched feedback divider |
| cfg_post | output | 2 | Latched post-divider code |
| cfg_test | output | 3 | Latched test-mode select |
| cfg_ratio | output | 4 | One-hot post-divide ratio |
| fb_zero | output | 1 | Latched feedback divider equals zero |

## Verification
The bench goes after four corner cases:
- **Opposite strobe polarities.** It checks the outputs between the rise and the fall of the serial strobe. A design that loaded on the wrong serial edge would change the outputs one step early.
- **Lock-out while the parallel strobe is low.** A design without it would take a serial word that should have been dropped.
- **Both strobes in the same cycle.** A parallel edge and a serial edge land together. Reversed priority would show the serial divider value and a changed test field.
- **Over-long shift and zero divider.** Sixteen bits are shifted before a load, which exposes wrong bit order or wrong register length. A zero divider must raise the flag and still be driven on `cfg_fb`.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  parameter int FB_W   = 9;
  parameter int POST_W = 2;
  parameter int TEST_W = 3;
  parameter int WORD_W = TEST_W + POST_W + FB_W;
  parameter int RATIO_W = 1 << POST_W;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [POST_W-1:0] post;
    logic [FB_W-1:0]   fb;
  } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
// Multi-lane level synchronizer: STAGES flops per lane.
module cfg_sync #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_in,
  output logic [LANES-1:0] sync_lvl
);
  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      logic [STAGES-1:0] pipe_q;
      logic [STAGES-1:0] pipe_d;

      always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], async_in[gi]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
      end

      assign sync_lvl[gi] = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfg_edge.sv
// Per-lane edge detector; RISE_MASK bit set selects a rising edge, clear a falling edge.
module cfg_edge #(
  parameter int               LANES     = 3,
  parameter logic [LANES-1:0] RISE_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] evt
);
  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_det
      if (RISE_MASK[gi]) begin : g_rise
        assign evt[gi] = lvl[gi] & ~prev_q[gi];
      end else begin : g_fall
        assign evt[gi] = ~lvl[gi] & prev_q[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_shift.sv
// Serial capture register, MSB first: new bit enters at bit 0.
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (adv) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign word = sr_q;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (sr_q[0] == $past(din)) && (sr_q[W-1:1] == $past(sr_q[W-2:0]))); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sr_q)); // R9
endmodule

// File: rtl/cfg_latch.sv
// Configuration registers shared by both load paths; parallel has priority.
module cfg_latch
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_evt,
  input  logic              par_lvl,
  input  logic              ser_evt,
  input  logic [FB_W-1:0]   par_fb,
  input  logic [POST_W-1:0] par_post,
  input  cfg_word_t         ser_word,
  output cfg_word_t         cfg
);
  cfg_word_t cfg_q;
  cfg_word_t cfg_d;
  logic      ld_par;
  logic      ld_ser;
  logic      ld_en;

  always_comb begin
    ld_par = par_evt;
    ld_ser = ser_evt & par_lvl & ~par_evt;
    ld_en  = ld_par | ld_ser;
    cfg_d  = cfg_q;
    if (ld_par) begin
      cfg_d.fb   = par_fb;
      cfg_d.post = par_post;
    end else if (ld_ser) begin
      cfg_d = ser_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.test <= '0;
      cfg_q.post <= '1;
      cfg_q.fb   <= '1;
    end else if (ld_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> (cfg_q.fb == $past(par_fb)) && (cfg_q.post == $past(par_post))); // R6
  AST_PAR_KEEPS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> $stable(cfg_q.test)); // R4
  AST_SER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_evt && !par_lvl) |=> $stable(cfg_q)); // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_evt && !ser_evt) |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/cfg_ratio_dec.sv
// One-hot decode of the post-divider code.
module cfg_ratio_dec #(
  parameter int CODE_W = 2,
  localparam int OUT_W = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  ratio
);
  genvar gi;
  generate
    for (gi = 0; gi < OUT_W; gi++) begin : g_bit
      assign ratio[gi] = (code == CODE_W'(gi));
    end
  endgenerate

  always_comb begin
    AST_RATIO_ONEHOT: assert ($countones(ratio) == 1); // R7
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_ld,
  input  logic              par_ld,
  input  logic [FB_W-1:0]   par_fb,
  input  logic [POST_W-1:0] par_post,
  output logic [FB_W-1:0]   cfg_fb,
  output logic [POST_W-1:0] cfg_post,
  output logic [TEST_W-1:0] cfg_test,
  output logic [RATIO_W-1:0] cfg_ratio,
  output logic              fb_zero
);
  localparam int LN_SCLK = 0;
  localparam int LN_SLD  = 1;
  localparam int LN_PLD  = 2;
  localparam int LN_SDAT = 3;
  localparam int N_LANES = 4;
  localparam int N_EDGES = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic [N_LANES-1:0] raw_in;
  logic [N_LANES-1:0] lvl;
  logic [N_EDGES-1:0] evt;
  cfg_word_t          sr_word;
  cfg_word_t          cfg;
  logic [WORD_W-1:0]  sr_bits;

  assign raw_in = {ser_dat, par_ld, ser_ld, ser_clk};

  cfg_sync #(.LANES(N_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_ni),
    .async_in (raw_in),
    .sync_lvl (lvl)
  );

  // serial clock: rising, serial load: falling, parallel load: rising
  cfg_edge #(.LANES(N_EDGES), .RISE_MASK(3'b101)) u_edge (
    .clk   (clk),
    .rst_n (rst_ni),
    .lvl   (lvl[N_EDGES-1:0]),
    .evt   (evt)
  );

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_ni),
    .adv   (evt[LN_SCLK]),
    .din   (lvl[LN_SDAT]),
    .word  (sr_bits)
  );
  assign sr_word = cfg_word_t'(sr_bits);

  cfg_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_ni),
    .par_evt  (evt[LN_PLD]),
    .par_lvl  (lvl[LN_PLD]),
    .ser_evt  (evt[LN_SLD]),
    .par_fb   (par_fb),
    .par_post (par_post),
    .ser_word (sr_word),
    .cfg      (cfg)
  );

  cfg_ratio_dec #(.CODE_W(POST_W)) u_dec (
    .code  (cfg.post),
    .ratio (cfg_ratio)
  );

  assign cfg_fb   = cfg.fb;
  assign cfg_post = cfg.post;
  assign cfg_test = cfg.test;
  assign fb_zero  = (cfg.fb == '0);

  AST_ZERO_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(fb_zero) |-> $past(evt[LN_PLD] || evt[LN_SLD])); // R8
endmodule

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_dat, ser_ld, par_ld;
  logic [8:0] par_fb;
  logic [1:0] par_post;
  logic [8:0] cfg_fb;
  logic [1:0] cfg_post;
  logic [2:0] cfg_test;
  logic [3:0] cfg_ratio;
  logic       fb_zero;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  synth_cfg_port u_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .par_ld(par_ld), .par_fb(par_fb), .par_post(par_post),
    .cfg_fb(cfg_fb), .cfg_post(cfg_post), .cfg_test(cfg_test),
    .cfg_ratio(cfg_ratio), .fb_zero(fb_zero)
  );

  // {is_parallel, test[2:0], post[1:0], fb[8:0]}
  localparam logic [14:0] VEC [6] = '{
    {1'b0, 3'd5, 2'd0, 9'h0A5},
    {1'b0, 3'd2, 2'd1, 9'h1FF},
    {1'b1, 3'd0, 2'd2, 9'h123},
    {1'b0, 3'd7, 2'd3, 9'h000},
    {1'b1, 3'd0, 2'd3, 9'h001},
    {1'b0, 3'd0, 2'd2, 9'h155}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [2:0] t, input logic [1:0] n,
                         input logic [8:0] m);
    chk({tag, " fb"},    16'(cfg_fb),    16'(m));
    chk({tag, " post"},  16'(cfg_post),  16'(n));
    chk({tag, " test"},  16'(cfg_test),  16'(t));
    chk({tag, " ratio R7"}, 16'(cfg_ratio), 16'(4'b0001 << n));
    chk({tag, " zero R8"},  16'(fb_zero),   16'(m == 9'd0));
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      tick(2);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(3);
    end
  endtask

  task automatic ser_pulse();
    ser_ld = 1'b1;
    tick(4);
    ser_ld = 1'b0;
    tick(5);
  endtask

  task automatic par_load(input logic [8:0] m, input logic [1:0] n);
    par_ld = 1'b0;
    tick(4);
    par_fb = m;
    par_post = n;
    tick(2);
    par_ld = 1'b1;
    tick(5);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] et;
    logic [1:0] en;
    logic [8:0] em;
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0; par_ld = 1'b0;
    par_fb = 9'h1FF; par_post = 2'b11;
    tick(4);
    chk_all("R1 reset", 3'd0, 2'd3, 9'h1FF);
    rst_n = 1'b1;
    tick(6);
    par_ld = 1'b1;
    tick(6);
    chk_all("R1 after release", 3'd0, 2'd3, 9'h1FF);
    et = 3'd0; en = 2'd3; em = 9'h1FF;

    for (int k = 0; k < 6; k++) begin
      if (VEC[k][14]) begin
        par_load(VEC[k][8:0], VEC[k][10:9]);
        en = VEC[k][10:9]; em = VEC[k][8:0];
        chk_all("R4 parallel table", et, en, em);
      end else begin
        shift_bits({2'b00, VEC[k][13:0]}, 14);
        ser_pulse();
        et = VEC[k][13:11]; en = VEC[k][10:9]; em = VEC[k][8:0];
        chk_all("R2 serial table", et, en, em);
      end
    end

    // R3: rising serial strobe changes nothing, falling one loads
    shift_bits({2'b00, 3'd1, 2'd1, 9'h0F0}, 14);
    ser_ld = 1'b1;
    tick(6);
    chk_all("R3 rise ignored", et, en, em);
    ser_ld = 1'b0;
    tick(6);
    et = 3'd1; en = 2'd1; em = 9'h0F0;
    chk_all("R3 fall loads", et, en, em);

    // R5: serial load locked out while parallel strobe low
    par_ld = 1'b0;
    tick(4);
    shift_bits({2'b00, 3'd3, 2'd0, 9'h0AA}, 14);
    ser_pulse();
    chk_all("R5 locked out", et, en, em);
    par_fb = 9'h0C3; par_post = 2'd0;
    tick(2);
    par_ld = 1'b1;
    tick(6);
    en = 2'd0; em = 9'h0C3;
    chk_all("R4 keeps test", et, en, em);

    // R9: sixteen bits, only the last fourteen kept
    shift_bits({2'b11, 3'd6, 2'd1, 9'h10F}, 16);
    ser_pulse();
    et = 3'd6; en = 2'd1; em = 9'h10F;
    chk_all("R9 overshift", et, en, em);

    // R6: parallel rise and serial fall in the same cycle
    shift_bits({2'b00, 3'd4, 2'd3, 9'h011}, 14);
    par_ld = 1'b0;
    ser_ld = 1'b1;
    tick(4);
    par_fb = 9'h077; par_post = 2'd2;
    tick(2);
    par_ld = 1'b1;
    ser_ld = 1'b0;
    tick(6);
    en = 2'd2; em = 9'h077;
    chk_all("R6 priority", et, en, em);

    // R1: reset mid-run restores defaults
    rst_n = 1'b0;
    tick(2);
    chk_all("R1 mid-run reset", 3'd0, 2'd3, 9'h1FF);
    rst_n = 1'b1;
    tick(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule